// File: doc/BRIEF.md
# Paired-Page Translation Lookaside Buffer

This block is a small fully associative address translation cache. Every entry describes two neighbouring virtual pages, an even one and an odd one, that share a single tag and a single page-size field. Each half has its own physical frame number, cache attribute and valid bit. A translation request carries a virtual address and the current address-space identifier (ASID). One cycle later the block returns a hit flag, the physical frame base, the virtual base of the page that was selected, the page length, a cacheable flag and the index of the winning entry.

A second request type, the probe, searches the entries with a tag-register style word (virtual page pair number plus ASID). It reports the number of the matching entry or, on a miss, a word with only bit 31 set. Entries are loaded through a write port that replaces every field of one entry in a single clock. A mode input chooses between a 32-bit and a full-width virtual address compare. A bus-mask input limits the physical address to the width of the attached bus.

The sequencing is a three-state machine. ST_IDLE is held when no request is present. Any state moves to ST_XLATE when `xl_req` is high (transition "accept translation"). It moves to ST_PROBE when only `pr_req` is high (transition "accept probe"). With no request it returns to ST_IDLE (transition "drain"). The response registers are loaded on the edge that enters ST_XLATE or ST_PROBE. `xl_done` and `pr_done` show the current state.

Top module: `pair_tlb`

## Requirements
- R1: Reset clears every field of every entry, so both halves are invalid. It drops `xl_done` and `pr_done` and sets `pr_index` to 32'h8000_0000.
- R2: When `wr_en` is high at a clock edge, entry `wr_idx` takes `wr_hi`, `wr_lo0`, `wr_lo1` and the page-size field `wr_mask[24:13]`. A later write to the same index replaces all of these fields.
- R3: An entry's tag matches in two cases. First, the request address, masked by the mode mask and by the entry's compare mask, must equal the entry's tag word masked by the mode mask. Second, either the entry's global bit (tag bit 12) is set or its ASID (tag bits 7:0) equals `cur_asid`. The compare mask is the complement of (field<<13 plus 0x1FFF).
- R4: The reported page length is (field<<12) + 0x1000. A zero field gives 4 KiB.
- R5: The address bit whose weight equals the page length selects the half. When that bit is 0, the even half (`lo0`) is used and the virtual base is the address ANDed with the compare mask. When it is 1, the odd half (`lo1`) is used and the virtual base is that value plus the page length.
- R6: The physical frame base is the selected half's frame number (bits 29:6) placed at address bit 12 and up, ANDed with `pa_bus_mask`.
- R7: A half is valid when its bit 1 is set. Its cache field is bits 5:3. `xl_cached` is 0 only when that field is 3'b010.
- R8: The lowest-numbered tag match decides the result. If its selected half is invalid, the result is a miss even when a later entry would hit. `xl_idx` gives the winning entry on a hit and 0 on a miss.
- R9: With `wide_mode` low, only virtual address bits 31:13 take part in the tag compare. With it high, bits 39:13 take part.
- R10: A probe compares the tag word of `pr_hi` with each entry's tag word, without the page-size mask. It takes the ASID from `pr_hi[7:0]` and honours the global bit. The lowest matching entry number is written to `pr_index`; a miss writes 32'h8000_0000.
- R11: Results appear one cycle after the request, with `xl_done` or `pr_done` high for one cycle per request. A translation request takes precedence over a probe in the same cycle, and the probe is then dropped. `pr_index` changes only on an accepted probe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wide_mode | input | 1 | 1: full-width virtual compare, 0: 32-bit compare |
| pa_bus_mask | input | 36 | Physical bus mask applied to frame base |
| wr_en | input | 1 | Entry write strobe |
| wr_idx | input | 4 | Entry to write |
| wr_hi | input | 40 | Tag word: page pair bits 39:13, global bit 12, ASID 7:0 |
| wr_lo0 | input | 32 | Even half: frame 29:6, cache 5:3, valid 1 |
| wr_lo1 | input | 32 | Odd half, same layout |
| wr_mask | input | 32 | Page-size field in bits 24:13 |
| xl_req | input | 1 | Translation request |
| xl_va | input | 40 | Virtual address to translate |
| cur_asid | input | 8 | Current ASID for translation |
| pr_req | input | 1 | Probe request |
| pr_hi | input | 40 | Probe tag word |
| xl_done | output | 1 | Translation result valid (ST_XLATE) |
| xl_hit | output | 1 | Translation hit |
| xl_pa | output | 36 | Physical frame base |
| xl_vbase | output | 40 | Virtual base of selected page |
| xl_len | output | 32 | Page length in bytes |
| xl_cached | output | 1 | Cacheable attribute |
| xl_idx | output | 4 | Winning entry index |
| pr_done | output | 1 | Probe result valid (ST_PROBE) |
| pr_index | output | 32 | Probe result word |

## Verification
The hardest case to reach from the ports is a tag match on an early entry whose selected half is invalid while a later entry would translate the same address. Without that case, the rule that the search stops at the first tag match is never exercised. The stimulus sets it up in two ways. A 16 KiB entry with an invalid odd half is laid over a valid 4 KiB entry placed later, and the bench looks up an address in that odd half. Later, an entry that shares its tag with a higher entry is rewritten with its even half invalid, and the bench looks up the same address again.

// File: rtl/pair_tlb_pkg.sv
package pair_tlb_pkg;

    // tag word layout
    localparam int ASID_W     = 8;
    localparam int TAG_G_BIT  = 12;
    localparam int VPN_LSB    = 13;
    localparam int NARROW_W   = 32;

    // half-entry word layout
    localparam int LO_W       = 32;
    localparam int LO_V_BIT   = 1;
    localparam int LO_C_LSB   = 3;
    localparam int LO_C_W     = 3;
    localparam int LO_PFN_LSB = 6;

    // page-size field inside the mask word
    localparam int MF_LSB     = 13;
    localparam int MF_W       = 12;

    localparam int PAGE_SHIFT = 12;
    localparam int LOW_ONES   = (1 << VPN_LSB) - 1;
    localparam int BASE_PAGE  = 1 << PAGE_SHIFT;

    localparam logic [LO_C_W-1:0] C_UNCACHED = 3'b010;
    localparam logic [31:0]       PR_MISS    = 32'h8000_0000;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_XLATE = 2'd1,
        ST_PROBE = 2'd2
    } tlb_state_e;

endpackage

// File: rtl/pair_tlb_store.sv
module pair_tlb_store
    import pair_tlb_pkg::*;
#(
    parameter int N_ENT = 16,
    parameter int VA_W  = 40,
    parameter int IDX_W = 4
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [IDX_W-1:0]                 wr_idx,
    input  logic [VA_W-1:0]                  wr_hi,
    input  logic [LO_W-1:0]                  wr_lo0,
    input  logic [LO_W-1:0]                  wr_lo1,
    input  logic [31:0]                      wr_mask,
    output logic [N_ENT-1:0][VA_W-1:0]       ent_hi,
    output logic [N_ENT-1:0][LO_W-1:0]       ent_lo0,
    output logic [N_ENT-1:0][LO_W-1:0]       ent_lo1,
    output logic [N_ENT-1:0][MF_W-1:0]       ent_mf
);

    // one register bank per entry; reset leaves every half invalid
    for (genvar i = 0; i < N_ENT; i++) begin : g_ent
        logic hit_wr;
        assign hit_wr = wr_en && (wr_idx == IDX_W'(i));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_hi[i]  <= '0;
                ent_lo0[i] <= '0;
                ent_lo1[i] <= '0;
                ent_mf[i]  <= '0;
            end else if (hit_wr) begin
                ent_hi[i]  <= wr_hi;
                ent_lo0[i] <= wr_lo0;
                ent_lo1[i] <= wr_lo1;
                ent_mf[i]  <= wr_mask[MF_LSB +: MF_W];
            end
        end
    end

endmodule

// File: rtl/pair_tlb_match.sv
module pair_tlb_match
    import pair_tlb_pkg::*;
#(
    parameter int N_ENT = 16,
    parameter int VA_W  = 40
) (
    input  logic                        wide_mode,
    input  logic [VA_W-1:0]             xl_va,
    input  logic [ASID_W-1:0]           cur_asid,
    input  logic [VA_W-1:0]             pr_hi,
    input  logic [N_ENT-1:0][VA_W-1:0]  ent_hi,
    input  logic [N_ENT-1:0][MF_W-1:0]  ent_mf,
    output logic [N_ENT-1:0]            xl_tag,
    output logic [N_ENT-1:0]            pr_tag
);

    localparam logic [VA_W-1:0] VMASK_WIDE =
        {{(VA_W-VPN_LSB){1'b1}}, {VPN_LSB{1'b0}}};
    localparam logic [VA_W-1:0] VMASK_NARROW =
        {{(VA_W-NARROW_W){1'b0}}, {(NARROW_W-VPN_LSB){1'b1}}, {VPN_LSB{1'b0}}};

    logic [VA_W-1:0] vmask;
    logic [VA_W-1:0] va_vpn;
    logic [VA_W-1:0] pr_vpn;

    assign vmask  = wide_mode ? VMASK_WIDE : VMASK_NARROW;
    assign va_vpn = xl_va & vmask;
    assign pr_vpn = pr_hi & vmask;

    // one comparator pair per entry
    for (genvar i = 0; i < N_ENT; i++) begin : g_cmp
        logic [VA_W-1:0] cmp_mask;
        logic [VA_W-1:0] tag_vpn;
        logic            is_global;
        logic            xl_asid_ok;
        logic            pr_asid_ok;

        assign cmp_mask   = ~((VA_W'(ent_mf[i]) << MF_LSB) + VA_W'(LOW_ONES));
        assign tag_vpn    = ent_hi[i] & vmask;
        assign is_global  = ent_hi[i][TAG_G_BIT];
        assign xl_asid_ok = is_global || (ent_hi[i][ASID_W-1:0] == cur_asid);
        assign pr_asid_ok = is_global || (ent_hi[i][ASID_W-1:0] == pr_hi[ASID_W-1:0]);

        assign xl_tag[i]  = ((va_vpn & cmp_mask) == tag_vpn) && xl_asid_ok;
        assign pr_tag[i]  = (pr_vpn == tag_vpn) && pr_asid_ok;
    end

endmodule

// File: rtl/pair_tlb_prio.sv
module pair_tlb_prio #(
    parameter int N_ENT = 16,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_ENT-1:0] req,
    output logic             found,
    output logic [IDX_W-1:0] idx,
    output logic [N_ENT-1:0] first_oh
);

    // lowest set bit wins
    always_comb begin
        found    = 1'b0;
        idx      = '0;
        first_oh = '0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (req[i]) begin
                found       = 1'b1;
                idx         = IDX_W'(i);
                first_oh    = '0;
                first_oh[i] = 1'b1;
            end
        end
    end

    // R8: a single winner, itself requesting, with nothing lower requesting
    a_r8_single_winner: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> ($countones(first_oh) == 1));
    a_r8_winner_requests: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> req[idx]);
    a_r8_none_lower: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> ((req & (first_oh - N_ENT'(1))) == '0));
    a_r8_empty_none: assert property (@(posedge clk) disable iff (!rst_n)
        (req == '0) |-> !found);

endmodule

// File: rtl/pair_tlb.sv
module pair_tlb
    import pair_tlb_pkg::*;
#(
    parameter int N_ENT = 16,
    parameter int VA_W  = 40,
    parameter int PA_W  = 36
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wide_mode,
    input  logic [PA_W-1:0]               pa_bus_mask,
    input  logic                          wr_en,
    input  logic [$clog2(N_ENT)-1:0]      wr_idx,
    input  logic [VA_W-1:0]               wr_hi,
    input  logic [31:0]                   wr_lo0,
    input  logic [31:0]                   wr_lo1,
    input  logic [31:0]                   wr_mask,
    input  logic                          xl_req,
    input  logic [VA_W-1:0]               xl_va,
    input  logic [7:0]                    cur_asid,
    input  logic                          pr_req,
    input  logic [VA_W-1:0]               pr_hi,
    output logic                          xl_done,
    output logic                          xl_hit,
    output logic [PA_W-1:0]               xl_pa,
    output logic [VA_W-1:0]               xl_vbase,
    output logic [31:0]                   xl_len,
    output logic                          xl_cached,
    output logic [$clog2(N_ENT)-1:0]      xl_idx,
    output logic                          pr_done,
    output logic [31:0]                   pr_index
);

    localparam int IDX_W = $clog2(N_ENT);
    localparam int PFN_W = PA_W - PAGE_SHIFT;

    // entry storage
    logic [N_ENT-1:0][VA_W-1:0] ent_hi;
    logic [N_ENT-1:0][LO_W-1:0] ent_lo0;
    logic [N_ENT-1:0][LO_W-1:0] ent_lo1;
    logic [N_ENT-1:0][MF_W-1:0] ent_mf;

    pair_tlb_store #(.N_ENT(N_ENT), .VA_W(VA_W), .IDX_W(IDX_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_hi   (wr_hi),
        .wr_lo0  (wr_lo0),
        .wr_lo1  (wr_lo1),
        .wr_mask (wr_mask),
        .ent_hi  (ent_hi),
        .ent_lo0 (ent_lo0),
        .ent_lo1 (ent_lo1),
        .ent_mf  (ent_mf)
    );

    // per-entry match lines
    logic [N_ENT-1:0] xl_tag;
    logic [N_ENT-1:0] pr_tag;

    pair_tlb_match #(.N_ENT(N_ENT), .VA_W(VA_W)) u_match (
        .wide_mode (wide_mode),
        .xl_va     (xl_va),
        .cur_asid  (cur_asid),
        .pr_hi     (pr_hi),
        .ent_hi    (ent_hi),
        .ent_mf    (ent_mf),
        .xl_tag    (xl_tag),
        .pr_tag    (pr_tag)
    );

    // priority pick for each search
    logic             xl_found;
    logic [IDX_W-1:0] xl_sel;
    logic [N_ENT-1:0] xl_oh;
    logic             pr_found;
    logic [IDX_W-1:0] pr_sel;
    logic [N_ENT-1:0] pr_oh;

    pair_tlb_prio #(.N_ENT(N_ENT), .IDX_W(IDX_W)) u_xl_prio (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (xl_tag),
        .found    (xl_found),
        .idx      (xl_sel),
        .first_oh (xl_oh)
    );

    pair_tlb_prio #(.N_ENT(N_ENT), .IDX_W(IDX_W)) u_pr_prio (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (pr_tag),
        .found    (pr_found),
        .idx      (pr_sel),
        .first_oh (pr_oh)
    );

    // page attributes of the winning entry only
    logic [MF_W-1:0]  sel_mf;
    logic [VA_W-1:0]  sel_size;
    logic [VA_W-1:0]  sel_cmask;
    logic             sel_odd;
    logic [LO_W-1:0]  sel_lo;
    logic             sel_valid;
    logic [PA_W-1:0]  sel_pa;
    logic [VA_W-1:0]  sel_vbase;
    logic             sel_cached;

    always_comb begin
        sel_mf     = ent_mf[xl_sel];
        sel_size   = (VA_W'(sel_mf) << PAGE_SHIFT) + VA_W'(BASE_PAGE);
        sel_cmask  = ~((VA_W'(sel_mf) << MF_LSB) + VA_W'(LOW_ONES));
        sel_odd    = |(xl_va & sel_size);
        sel_lo     = sel_odd ? ent_lo1[xl_sel] : ent_lo0[xl_sel];
        sel_valid  = sel_lo[LO_V_BIT];
        sel_pa     = {sel_lo[LO_PFN_LSB +: PFN_W], {PAGE_SHIFT{1'b0}}} & pa_bus_mask;
        sel_vbase  = (xl_va & sel_cmask) + (sel_odd ? sel_size : '0);
        sel_cached = (sel_lo[LO_C_LSB +: LO_C_W] != C_UNCACHED);
    end

    // request state machine
    tlb_state_e state_q;
    tlb_state_e state_d;

    always_comb begin
        unique case (state_q)
            ST_IDLE, ST_XLATE, ST_PROBE: begin
                if (xl_req) begin
                    state_d = ST_XLATE;
                end else if (pr_req) begin
                    state_d = ST_PROBE;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // response registers, loaded on entry to a response state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xl_hit    <= 1'b0;
            xl_pa     <= '0;
            xl_vbase  <= '0;
            xl_len    <= '0;
            xl_cached <= 1'b0;
            xl_idx    <= '0;
            pr_index  <= PR_MISS;
        end else begin
            unique case (state_d)
                ST_XLATE: begin
                    xl_hit    <= xl_found && sel_valid;
                    xl_pa     <= sel_pa;
                    xl_vbase  <= sel_vbase;
                    xl_len    <= sel_size[31:0];
                    xl_cached <= sel_cached;
                    xl_idx    <= (xl_found && sel_valid) ? xl_sel : '0;
                end
                ST_PROBE: begin
                    pr_index  <= pr_found ? 32'(pr_sel) : PR_MISS;
                end
                default: begin
                end
            endcase
        end
    end

    assign xl_done = (state_q == ST_XLATE);
    assign pr_done = (state_q == ST_PROBE);

    // R11: response timing, exclusivity and probe-result hold
    a_r11_xl_next: assert property (@(posedge clk) disable iff (!rst_n)
        xl_req |=> (xl_done && !pr_done));
    a_r11_pr_next: assert property (@(posedge clk) disable iff (!rst_n)
        (pr_req && !xl_req) |=> pr_done);
    a_r11_pr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!pr_req || xl_req) |=> $stable(pr_index));
    a_r11_one_resp: assert property (@(posedge clk) disable iff (!rst_n)
        !(xl_done && pr_done));
    // R6: frame base never outside the bus mask used at request time
    a_r6_pa_in_bus: assert property (@(posedge clk) disable iff (!rst_n)
        xl_req |=> ((xl_pa & ~$past(pa_bus_mask)) == '0));
    // R4: page length a power of two on a hit
    a_r4_len_pow2: assert property (@(posedge clk) disable iff (!rst_n)
        (xl_done && xl_hit) |-> ($countones(xl_len) == 1));
    // R5: virtual base aligned to the page length
    a_r5_vbase_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (xl_done && xl_hit) |-> ((xl_vbase & (VA_W'(xl_len) - VA_W'(1))) == '0));
    // R10: probe word is an entry number or the miss word
    a_r10_index_form: assert property (@(posedge clk) disable iff (!rst_n)
        pr_done |-> ((pr_index == PR_MISS) || (pr_index < 32'(N_ENT))));
    // R8: a miss reports index zero
    a_r8_miss_idx: assert property (@(posedge clk) disable iff (!rst_n)
        (xl_done && !xl_hit) |-> (xl_idx == '0));

endmodule

// File: tb/pair_tlb_test.sv
module pair_tlb_test;

    typedef struct packed {
        logic        wide;
        logic [35:0] bmask;
        logic [39:0] va;
        logic [7:0]  asid;
        logic        hit;
        logic [35:0] pa;
        logic [39:0] vb;
        logic [31:0] len;
        logic        cached;
        logic [3:0]  idx;
    } vec_t;

    localparam logic [35:0] BM_ALL = 36'hF_FFFF_FFFF;
    localparam int NV = 13;

    // R9 is covered by rows 6, 7 and 8 (mode-dependent compare)
    localparam vec_t VECS [NV] = '{
        '{1'b0, BM_ALL, 40'h00_0001_0123, 8'h05, 1'b1, 36'h0_0010_0000, 40'h00_0001_0000, 32'h0000_1000, 1'b1, 4'd0},
        '{1'b0, BM_ALL, 40'h00_0001_1FFF, 8'h05, 1'b1, 36'h0_0010_1000, 40'h00_0001_1000, 32'h0000_1000, 1'b0, 4'd0},
        '{1'b0, BM_ALL, 40'h00_0001_0123, 8'h06, 1'b0, 36'h0,           40'h0,            32'h0,         1'b0, 4'd0},
        '{1'b0, BM_ALL, 40'h00_0010_2345, 8'h33, 1'b1, 36'h0_0200_0000, 40'h00_0010_0000, 32'h0000_4000, 1'b1, 4'd1},
        '{1'b0, BM_ALL, 40'h00_0010_6000, 8'h00, 1'b0, 36'h0,           40'h0,            32'h0,         1'b0, 4'd0},
        '{1'b0, BM_ALL, 40'h00_0020_0010, 8'h07, 1'b1, 36'h0_0040_0000, 40'h00_0020_0000, 32'h0000_1000, 1'b1, 4'd3},
        '{1'b1, BM_ALL, 40'h12_0000_0040, 8'h00, 1'b1, 36'h0_0060_0000, 40'h12_0000_0000, 32'h0000_1000, 1'b1, 4'd5},
        '{1'b0, BM_ALL, 40'h99_0001_0123, 8'h05, 1'b1, 36'h0_0010_0000, 40'h99_0001_0000, 32'h0000_1000, 1'b1, 4'd0},
        '{1'b1, BM_ALL, 40'h99_0001_0123, 8'h05, 1'b0, 36'h0,           40'h0,            32'h0,         1'b0, 4'd0},
        '{1'b0, BM_ALL, 40'h00_0041_2345, 8'h01, 1'b1, 36'h0_0701_0000, 40'h00_0041_0000, 32'h0001_0000, 1'b0, 4'd6},
        '{1'b0, 36'h0_00FF_FFFF, 40'h00_0010_2345, 8'h33, 1'b1, 36'h0, 40'h00_0010_0000, 32'h0000_4000, 1'b1, 4'd1},
        '{1'b0, BM_ALL, 40'h00_0040_8000, 8'h02, 1'b0, 36'h0,           40'h0,            32'h0,         1'b0, 4'd0},
        '{1'b0, BM_ALL, 40'h00_0040_8000, 8'h01, 1'b1, 36'h0_0700_0000, 40'h00_0040_0000, 32'h0001_0000, 1'b1, 4'd6}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wide_mode = 1'b0;
    logic [35:0] pa_bus_mask = BM_ALL;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic [39:0] wr_hi = '0;
    logic [31:0] wr_lo0 = '0;
    logic [31:0] wr_lo1 = '0;
    logic [31:0] wr_mask = '0;
    logic        xl_req = 1'b0;
    logic [39:0] xl_va = '0;
    logic [7:0]  cur_asid = '0;
    logic        pr_req = 1'b0;
    logic [39:0] pr_hi = '0;
    logic        xl_done;
    logic        xl_hit;
    logic [35:0] xl_pa;
    logic [39:0] xl_vbase;
    logic [31:0] xl_len;
    logic        xl_cached;
    logic [3:0]  xl_idx;
    logic        pr_done;
    logic [31:0] pr_index;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    pair_tlb uut (
        .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode), .pa_bus_mask(pa_bus_mask),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_hi(wr_hi), .wr_lo0(wr_lo0), .wr_lo1(wr_lo1),
        .wr_mask(wr_mask), .xl_req(xl_req), .xl_va(xl_va), .cur_asid(cur_asid),
        .pr_req(pr_req), .pr_hi(pr_hi), .xl_done(xl_done), .xl_hit(xl_hit), .xl_pa(xl_pa),
        .xl_vbase(xl_vbase), .xl_len(xl_len), .xl_cached(xl_cached), .xl_idx(xl_idx),
        .pr_done(pr_done), .pr_index(pr_index)
    );

    function automatic logic [31:0] mk_lo(input logic [23:0] pfn, input logic [2:0] c, input logic v);
        return ({8'h00, pfn} << 6) | (32'(c) << 3) | (32'(v) << 1);
    endfunction

    task automatic check(input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic write_ent(input logic [3:0] i, input logic [39:0] hi,
                             input logic [31:0] lo0, input logic [31:0] lo1, input logic [31:0] msk);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = i; wr_hi = hi; wr_lo0 = lo0; wr_lo1 = lo1; wr_mask = msk;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic lookup(input logic wide, input logic [35:0] bm, input logic [39:0] va, input logic [7:0] asid);
        @(negedge clk);
        wide_mode = wide; pa_bus_mask = bm; xl_va = va; cur_asid = asid; xl_req = 1'b1;
        @(negedge clk);
        xl_req = 1'b0;
    endtask

    task automatic probe(input logic [39:0] hi);
        @(negedge clk);
        pr_hi = hi; pr_req = 1'b1;
        @(negedge clk);
        pr_req = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 xl_done after reset", 64'(xl_done), 64'd0);
        check("R1 pr_done after reset", 64'(pr_done), 64'd0);
        check("R1 pr_index after reset", 64'(pr_index), 64'h8000_0000);
        lookup(1'b0, BM_ALL, 40'h00_0001_0123, 8'h05);
        check("R1 empty table misses", 64'(xl_hit), 64'd0);

        // R2: program entries
        write_ent(4'd0, 40'h00_0001_0005, mk_lo(24'h100, 3'd3, 1'b1), mk_lo(24'h101, 3'd2, 1'b1), 32'h0);
        write_ent(4'd1, 40'h00_0010_1009, mk_lo(24'h2000, 3'd3, 1'b1), mk_lo(24'h2004, 3'd3, 1'b0), 32'h6000);
        write_ent(4'd2, 40'h00_0010_7000, mk_lo(24'h300, 3'd3, 1'b1), mk_lo(24'h301, 3'd3, 1'b1), 32'h0);
        write_ent(4'd3, 40'h00_0020_0007, mk_lo(24'h400, 3'd3, 1'b1), mk_lo(24'h401, 3'd3, 1'b1), 32'h0);
        write_ent(4'd4, 40'h00_0020_0007, mk_lo(24'h500, 3'd3, 1'b1), mk_lo(24'h501, 3'd3, 1'b1), 32'h0);
        write_ent(4'd5, 40'h12_0000_1000, mk_lo(24'h600, 3'd3, 1'b1), mk_lo(24'h601, 3'd3, 1'b0), 32'h0);
        write_ent(4'd6, 40'h00_0040_0001, mk_lo(24'h7000, 3'd0, 1'b1), mk_lo(24'h7010, 3'd2, 1'b1), 32'h1E000);

        // table walk: R3 R4 R5 R6 R7 R8 R9
        for (int k = 0; k < NV; k++) begin
            lookup(VECS[k].wide, VECS[k].bmask, VECS[k].va, VECS[k].asid);
            check("R11 xl_done pulse", 64'(xl_done), 64'd1);
            check("R3 hit", 64'(xl_hit), 64'(VECS[k].hit));
            check("R8 index", 64'(xl_idx), 64'(VECS[k].idx));
            if (VECS[k].hit) begin
                check("R6 frame base", 64'(xl_pa), 64'(VECS[k].pa));
                check("R5 virtual base", 64'(xl_vbase), 64'(VECS[k].vb));
                check("R4 page length", 64'(xl_len), 64'(VECS[k].len));
                check("R7 cached", 64'(xl_cached), 64'(VECS[k].cached));
            end
        end
        @(negedge clk);
        check("R11 xl_done single cycle", 64'(xl_done), 64'd0);

        // R10: probes
        probe(40'h00_0001_0005);
        check("R11 pr_done pulse", 64'(pr_done), 64'd1);
        check("R10 probe asid match", 64'(pr_index), 64'd0);
        probe(40'h00_0010_0077);
        check("R10 probe global", 64'(pr_index), 64'd1);
        probe(40'h00_0010_4000);
        check("R10 probe ignores page size", 64'(pr_index), 64'h8000_0000);
        probe(40'h00_0020_0007);
        check("R10 probe lowest index", 64'(pr_index), 64'd3);
        probe(40'h00_0001_0006);
        check("R10 probe asid miss", 64'(pr_index), 64'h8000_0000);

        // R11: translation takes precedence, probe dropped
        @(negedge clk);
        wide_mode = 1'b0; pa_bus_mask = BM_ALL; xl_va = 40'h00_0001_0123; cur_asid = 8'h05;
        pr_hi = 40'h00_0020_0007; xl_req = 1'b1; pr_req = 1'b1;
        @(negedge clk);
        xl_req = 1'b0; pr_req = 1'b0;
        check("R11 both: xl_done", 64'(xl_done), 64'd1);
        check("R11 both: no pr_done", 64'(pr_done), 64'd0);
        check("R11 both: pr_index held", 64'(pr_index), 64'h8000_0000);
        @(negedge clk);
        check("R11 both: probe not deferred", 64'(pr_done), 64'd0);

        // R2 + R8: rewrite entry 3 with even half invalid; entry 4 must not be used
        write_ent(4'd3, 40'h00_0020_0007, mk_lo(24'h400, 3'd3, 1'b0), mk_lo(24'h401, 3'd3, 1'b1), 32'h0);
        lookup(1'b0, BM_ALL, 40'h00_0020_0010, 8'h07);
        check("R8 invalid first match hides later", 64'(xl_hit), 64'd0);
        check("R8 miss index", 64'(xl_idx), 64'd0);
        lookup(1'b0, BM_ALL, 40'h00_0020_1010, 8'h07);
        check("R2 rewritten odd half", 64'(xl_pa), 64'h0_0040_1000);

        // R1: reset mid-run clears entries
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        check("R1 pr_index after rerun reset", 64'(pr_index), 64'h8000_0000);
        lookup(1'b0, BM_ALL, 40'h00_0001_0123, 8'h05);
        check("R1 entries cleared", 64'(xl_hit), 64'd0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule